// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block gathers interrupt requests for one processor core, arbitrates among them, and hands the winner to the core. Interrupt sources are grouped into priority levels. Each level holds a vector of source bits that can be set or reset one bit at a time. A one-bit status per level records whether anything in that level is still outstanding. A single strobe wipes every level at once.

When the core asks for arbitration, the block merges a software request word from the core with the outstanding external levels. It forms a summary word and a winning priority, then compares that priority with the core's current priority. A winner that strictly beats the current priority, at a word-aligned instruction address, produces a one-cycle take pulse and is held in a latch. A later commit strobe moves the held priority and summary into the interrupt-ID and interrupt-summary registers. Protocol misuse raises error pulses and otherwise has no effect.

Top module: `lvl_irq_arbiter`

## Requirements
- R1: A post request (`op_valid`=1, `op_clr`=0) sets bit `op_index` of level `op_level` and marks that level outstanding, from the next clock edge onward.
- R2: A clear request (`op_valid`=1, `op_clr`=1) resets the named bit. The level stays outstanding while any other bit of that level is still set, and stops being outstanding when its vector becomes all zero.
- R3: `clr_all` empties every level vector and every status bit at the next edge, and takes precedence over a post in the same cycle.
- R4: `pending` is 1 exactly when at least one level is outstanding and `inst_addr[1:0]` is 2'b00.
- R5: Each set `sw_req` bit i with 1 <= i <= 15 sets summary bit i and offers priority i. Among software bits the highest index wins. `sw_req` bit 0 and bits 16 to 31 are ignored.
- R6: Each outstanding level i with 16 <= i <= 31 sets summary bit i and offers priority i. Any such level outranks every software request, and the highest one wins. Outstanding levels 0 to 15 do not take part in arbitration.
- R7: An `arb_req` cycle produces an `irq_take` pulse in the following cycle only if the winning priority is nonzero, strictly greater than `cur_ipl`, and `inst_addr[1:0]` is 2'b00.
- R8: On a take, `lat_ipl` and `lat_sum` hold the winning priority and summary, and `info_valid` rises. A `commit` while `info_valid` is 1 copies them to `int_id` and `int_sum` and clears `info_valid` at that edge.
- R9: A request with `op_level` >= 32 or `op_index` >= 64 changes no state and pulses `op_err` for one cycle after it.
- R10: A `commit` while `info_valid` is 0 leaves `int_id` and `int_sum` unchanged and pulses `op_err` for one cycle after it.
- R11: `ast_err` is 1 whenever `ast_req` is nonzero. `ast_req` has no other effect.
- R12: After reset, no level is outstanding, `info_valid`, `irq_take` and `op_err` are 0, and `int_id`, `int_sum`, `lat_ipl` and `lat_sum` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Post or clear request strobe |
| op_clr | input | 1 | 0 = post, 1 = clear |
| op_level | input | 6 | Target level of the request |
| op_index | input | 7 | Target bit within the level |
| clr_all | input | 1 | Empty every level |
| sw_req | input | 32 | Software request word from the core |
| cur_ipl | input | 5 | Core's current priority level |
| inst_addr | input | 32 | Current instruction address |
| ast_req | input | 4 | Asynchronous trap request (unsupported) |
| arb_req | input | 1 | Arbitrate this cycle |
| commit | input | 1 | Copy held winner into ID and summary registers |
| pending | output | 1 | Something outstanding at an aligned address |
| irq_take | output | 1 | One-cycle take pulse |
| info_valid | output | 1 | Held winner awaiting commit |
| lat_ipl | output | 5 | Held winning priority |
| lat_sum | output | 32 | Held summary word |
| int_id | output | 5 | Interrupt-ID register |
| int_sum | output | 32 | Interrupt-summary register |
| op_err | output | 1 | Bad request or spurious commit pulse |
| ast_err | output | 1 | Unsupported asynchronous trap request |

## Verification
On every cycle, the assertions check that the status word tracks the emptiness of each level vector. They also check that a clear-all leaves nothing outstanding, that a take always beats the prior current priority and sets the valid flag, that a commit copies the held values, and that a spurious commit raises the error. Only the bench scenarios can show which level and summary win for given mixes of software and external requests. The same holds for the strict comparison at equal priority, the alignment gate, the partial clear that keeps a level outstanding, and the ignoring of out-of-range requests and of low levels during arbitration.

// File: rtl/lvl_irq_arbiter.sv
module lvl_irq_arbiter #(
  parameter int NUM_LEVELS = 32,
  parameter int SRC_W      = 64,
  parameter int SW_MIN     = 1,
  parameter int SW_MAX     = 16,
  parameter int EXT_MIN    = 16,
  parameter int EXT_MAX    = 32,
  parameter int ADDR_W     = 32,
  parameter int AST_W      = 4,
  localparam int IPL_W     = $clog2(NUM_LEVELS),
  localparam int LVL_W     = $clog2(NUM_LEVELS) + 1,
  localparam int IDX_W     = $clog2(SRC_W) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  input  logic                  op_clr,
  input  logic [LVL_W-1:0]      op_level,
  input  logic [IDX_W-1:0]      op_index,
  input  logic                  clr_all,
  input  logic [NUM_LEVELS-1:0] sw_req,
  input  logic [IPL_W-1:0]      cur_ipl,
  input  logic [ADDR_W-1:0]     inst_addr,
  input  logic [AST_W-1:0]      ast_req,
  input  logic                  arb_req,
  input  logic                  commit,
  output logic                  pending,
  output logic                  irq_take,
  output logic                  info_valid,
  output logic [IPL_W-1:0]      lat_ipl,
  output logic [NUM_LEVELS-1:0] lat_sum,
  output logic [IPL_W-1:0]      int_id,
  output logic [NUM_LEVELS-1:0] int_sum,
  output logic                  op_err,
  output logic                  ast_err
);

  logic [SRC_W-1:0]      vec [NUM_LEVELS];
  logic [NUM_LEVELS-1:0] status;
  logic [NUM_LEVELS-1:0] vec_nz;
  logic                  op_ok;
  logic [SRC_W-1:0]      bit_mask;
  logic                  aligned;
  logic [IPL_W-1:0]      win_ipl;
  logic [NUM_LEVELS-1:0] win_sum;
  logic                  take_now;

  assign op_ok    = op_valid && (op_level < LVL_W'(NUM_LEVELS)) && (op_index < IDX_W'(SRC_W));
  assign bit_mask = SRC_W'(1) << op_index[IDX_W-2:0];
  assign aligned  = (inst_addr[1:0] == 2'b00);
  assign pending  = (status != '0) && aligned;
  assign ast_err  = (ast_req != '0);

  always_ff @(posedge clk) begin
    for (int l = 0; l < NUM_LEVELS; l++) begin
      if (!rst_n || clr_all) begin
        vec[l]    <= '0;
        status[l] <= 1'b0;
      end else if (op_ok && op_level == LVL_W'(l)) begin
        if (op_clr) begin
          vec[l]    <= vec[l] & ~bit_mask;
          status[l] <= |(vec[l] & ~bit_mask);
        end else begin
          vec[l]    <= vec[l] | bit_mask;
          status[l] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    win_ipl = '0;
    win_sum = '0;
    for (int i = SW_MIN; i < SW_MAX; i++) begin
      if (sw_req[i]) begin
        win_sum[i] = 1'b1;
        win_ipl    = IPL_W'(i - SW_MIN + 1);
      end
    end
    for (int i = EXT_MIN; i < EXT_MAX; i++) begin
      if (status[i]) begin
        win_sum[i] = 1'b1;
        win_ipl    = IPL_W'(i);
      end
    end
  end

  assign take_now = arb_req && (win_ipl != '0) && (win_ipl > cur_ipl) && aligned;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_take   <= 1'b0;
      info_valid <= 1'b0;
      lat_ipl    <= '0;
      lat_sum    <= '0;
      int_id     <= '0;
      int_sum    <= '0;
      op_err     <= 1'b0;
    end else begin
      irq_take <= take_now;
      op_err   <= (op_valid && !op_ok) || (commit && !info_valid);
      if (commit && info_valid) begin
        int_id  <= lat_ipl;
        int_sum <= lat_sum;
      end
      if (take_now) begin
        lat_ipl    <= win_ipl;
        lat_sum    <= win_sum;
        info_valid <= 1'b1;
      end else if (commit) begin
        info_valid <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_nz
    assign vec_nz[g] = |vec[g];
  end

  p_status_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    status == vec_nz);

  p_clear_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (status == '0));

  p_take_above_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arb_req && !irq_take |=> irq_take |-> (lat_ipl > $past(cur_ipl)));

  p_take_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> info_valid);

  p_commit_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit && info_valid |=> (int_id == $past(lat_ipl)) && (int_sum == $past(lat_sum)));

  p_spurious_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !info_valid |=> op_err && $stable(int_id) && $stable(int_sum));

endmodule

// File: tb/test_lvl_irq_arbiter.sv
module test_lvl_irq_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0, op_clr = 1'b0, clr_all = 1'b0;
  logic [5:0]  op_level = '0;
  logic [6:0]  op_index = '0;
  logic [31:0] sw_req = '0;
  logic [4:0]  cur_ipl = '0;
  logic [31:0] inst_addr = '0;
  logic [3:0]  ast_req = '0;
  logic        arb_req = 1'b0, commit = 1'b0;
  logic        pending, irq_take, info_valid, op_err, ast_err;
  logic [4:0]  lat_ipl, int_id;
  logic [31:0] lat_sum, int_sum;

  int checks = 0;
  int errors = 0;
  logic [63:0] m_vec [32];
  logic [4:0]  q_ipl [$];
  logic [31:0] q_sum [$];

  always #2 clk = ~clk;

  lvl_irq_arbiter i_lvl_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_clr(op_clr),
    .op_level(op_level), .op_index(op_index), .clr_all(clr_all),
    .sw_req(sw_req), .cur_ipl(cur_ipl), .inst_addr(inst_addr),
    .ast_req(ast_req), .arb_req(arb_req), .commit(commit),
    .pending(pending), .irq_take(irq_take), .info_valid(info_valid),
    .lat_ipl(lat_ipl), .lat_sum(lat_sum), .int_id(int_id),
    .int_sum(int_sum), .op_err(op_err), .ast_err(ast_err));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic m_any();
    for (int l = 0; l < 32; l++) if (m_vec[l] != 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic do_op(input logic clr, input int lvl, input int idx, input logic exp_err, input string req);
    @(negedge clk);
    op_valid = 1'b1; op_clr = clr;
    op_level = 6'(lvl); op_index = 7'(idx);
    @(negedge clk);
    op_valid = 1'b0;
    if (lvl < 32 && idx < 64) begin
      if (clr) m_vec[lvl][idx] = 1'b0;
      else     m_vec[lvl][idx] = 1'b1;
    end
    #1 check(req, op_err, exp_err);
  endtask

  task automatic do_arb(input string req);
    logic [4:0]  e_ipl;
    logic [31:0] e_sum;
    e_ipl = '0; e_sum = '0;
    for (int i = 1; i <= 15; i++)
      if (sw_req[i]) begin e_sum[i] = 1'b1; e_ipl = 5'(i); end
    for (int i = 16; i <= 31; i++)
      if (m_vec[i] != 0) begin e_sum[i] = 1'b1; e_ipl = 5'(i); end
    if (e_ipl != 0 && e_ipl > cur_ipl && inst_addr[1:0] == 2'b00) begin
      q_ipl.push_back(e_ipl);
      q_sum.push_back(e_sum);
    end
    @(negedge clk);
    arb_req = 1'b1;
    @(negedge clk);
    arb_req = 1'b0;
    #1 check({req, " scoreboard drained"}, 64'(q_ipl.size()), 0);
  endtask

  task automatic do_commit(input logic exp_err, input logic [4:0] e_id, input logic [31:0] e_sum, input string req);
    @(negedge clk);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    #1;
    check({req, " op_err"}, op_err, exp_err);
    check({req, " int_id"}, int_id, e_id);
    check({req, " int_sum"}, int_sum, e_sum);
    check({req, " info_valid"}, info_valid, 1'b0);
  endtask

  always @(negedge clk) begin
    if (rst_n && irq_take) begin
      if (q_ipl.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 actual=take expected=no take");
      end else begin
        check("R8 lat_ipl", lat_ipl, q_ipl.pop_front());
        check("R8 lat_sum", lat_sum, q_sum.pop_front());
        check("R8 info_valid", info_valid, 1'b1);
      end
    end
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int l = 0; l < 32; l++) m_vec[l] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R12 pending", pending, 1'b0);
    check("R12 info_valid", info_valid, 1'b0);
    check("R12 irq_take", irq_take, 1'b0);
    check("R12 op_err", op_err, 1'b0);
    check("R12 int_id", int_id, 0);
    check("R12 int_sum", int_sum, 0);
    check("R12 lat_ipl", lat_ipl, 0);
    check("R12 lat_sum", lat_sum, 0);

    do_op(1'b0, 20, 5, 1'b0, "R1 post");
    check("R1 pending after post", pending, 1'b1);
    inst_addr = 32'h2;
    #1 check("R4 misaligned pending", pending, 1'b0);
    do_arb("R7 misaligned no take");
    inst_addr = 32'h1000;
    #1 check("R4 aligned pending", pending, 1'b1);

    sw_req = 32'h0000_0008;
    do_arb("R6 external overrides software");
    do_commit(1'b0, 5'd20, 32'h0010_0008, "R8 commit");
    do_commit(1'b1, 5'd20, 32'h0010_0008, "R10 spurious commit");

    cur_ipl = 5'd20;
    do_arb("R7 equal priority no take");
    cur_ipl = 5'd19;
    do_arb("R7 higher priority take");
    do_commit(1'b0, 5'd20, 32'h0010_0008, "R8 second commit");
    cur_ipl = 5'd0;

    do_op(1'b0, 20, 9, 1'b0, "R1 second bit");
    do_op(1'b1, 20, 5, 1'b0, "R2 partial clear");
    check("R2 level still outstanding", pending, 1'b1);
    do_op(1'b1, 20, 9, 1'b0, "R2 last clear");
    check("R2 level empty", pending, 1'b0);

    sw_req = 32'h8001_0085;
    do_arb("R5 software only");
    do_commit(1'b0, 5'd7, 32'h0000_0084, "R5 commit");

    sw_req = '0;
    do_op(1'b0, 5, 0, 1'b0, "R6 low level post");
    check("R6 low level pending", pending, 1'b1);
    do_arb("R6 low level not arbitrated");

    do_op(1'b0, 40, 3, 1'b1, "R9 bad level");
    do_op(1'b0, 25, 64, 1'b1, "R9 bad index");
    do_op(1'b1, 5, 0, 1'b0, "R9 clear low level");
    check("R9 no state from bad requests", pending, 1'b0);
    do_arb("R9 nothing to take");

    ast_req = 4'h2;
    #1 check("R11 ast_err", ast_err, 1'b1);
    check("R11 pending unaffected", pending, 1'b0);
    check("R11 info_valid unaffected", info_valid, 1'b0);
    ast_req = '0;
    #1 check("R11 ast_err low", ast_err, 1'b0);

    do_op(1'b0, 31, 63, 1'b0, "R1 top level");
    do_op(1'b0, 17, 0, 1'b0, "R1 another level");
    @(negedge clk);
    clr_all = 1'b1;
    op_valid = 1'b1; op_clr = 1'b0; op_level = 6'd22; op_index = 7'd1;
    @(negedge clk);
    clr_all = 1'b0; op_valid = 1'b0;
    for (int l = 0; l < 32; l++) m_vec[l] = '0;
    #1 check("R3 clear all", pending, 1'b0);
    do_arb("R3 nothing after clear all");

    repeat (2) @(negedge clk);
    check("end scoreboard empty", 64'(q_ipl.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule